// File: doc/BRIEF.md
# Unaligned Byte-to-Word Write Packer

This block takes a stream of bytes bound for flash memory that may begin at any byte address. It turns the stream into a series of 32-bit program requests, each aimed at a 4-byte-aligned word address. A transfer begins with a `start` pulse that carries the first byte address and the total byte count. The bytes then arrive over a valid/ready stream. The packer assembles one word at a time and hands it to a downstream program sequencer. It then waits for that sequencer's pass/fail response before it assembles the next word.

Byte lanes that the transfer does not cover are filled with 0xFF, so programming leaves those cells unchanged. These are the lanes below the start offset in the first word and the lanes past the last byte in the final word. A running count reports how many real data bytes have been committed, and padding never adds to it.

Back-pressure rules:
- A byte moves on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high only while a word is being assembled.
- A request moves on a clock edge where `pg_valid` and `pg_ready` are both high.
- Once raised, `pg_valid` holds with a steady address and word until it is accepted.
- A response is a single-cycle `rsp_valid` pulse, and the sequencer may send it only after accepting a request.

Top module: `wpack_top`

## Requirements
- R1: Every request address is a multiple of 4. The first request goes to the start address rounded down to a multiple of 4, and each later request goes to the previous address plus 4.
- R2: In the first word, the byte lanes below the start offset (the start address modulo 4) carry 0xFF.
- R3: In the last word, the byte lanes above the final data byte carry 0xFF. This applies both when the data ends inside the first word and when it ends inside a trailing word.
- R4: Within a word, the byte at the lowest address sits in bits 7:0 and the byte at address base+k sits in bits 8k+7:8k, so the layout is little-endian.
- R5: Exactly one request is issued per touched word, in rising address order. No byte of the next word is accepted until the previous request has received its response.
- R6: `in_ready` is high only while a word is being assembled. While `pg_valid` is high and `pg_ready` is low, `pg_valid`, `pg_addr` and `pg_data` stay unchanged on the next cycle.
- R7: A response with `rsp_fail` high ends the transfer at once. `done` pulses with `err_io` set, no further request is issued and no further byte is accepted.
- R8: `committed` rises after each passing response by the number of real data bytes in that word, never by padding. It never falls during a transfer, and a failed word adds nothing.
- R9: A zero-length start raises `done` on the cycle after the start, with `committed` at 0, both error flags low and no request issued.
- R10: A start with nonzero length whose address plus length exceeds `DEV_BYTES` raises `done` on the next cycle with `err_range` set. No request is issued and no byte is accepted. A transfer that ends exactly at `DEV_BYTES` is allowed.
- R11: `done` is a single-cycle pulse. `committed`, `err_io` and `err_range` hold their values from the end of a transfer until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer; sampled only while idle |
| st_addr | input | ADDR_W | First byte address |
| st_len | input | LEN_W | Number of bytes in the transfer |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_ready | output | 1 | Packer can take a byte |
| pg_valid | output | 1 | Program request valid |
| pg_addr | output | ADDR_W | Aligned word byte address |
| pg_data | output | 32 | Packed word, padded with 0xFF |
| pg_ready | input | 1 | Sequencer accepts the request |
| rsp_valid | input | 1 | Sequencer response strobe |
| rsp_fail | input | 1 | Response reports a failed program |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_io | output | 1 | Transfer aborted by a failed program |
| err_range | output | 1 | Transfer rejected as out of range |
| committed | output | LEN_W | Real bytes programmed successfully |

## Verification
The in-RTL assertions check several behaviours on every cycle:
- the request stays stable under back-pressure;
- `done` lasts one cycle;
- `committed` never decreases within a transfer;
- zero-length and out-of-range starts finish on the next cycle;
- the stream and request sides stay quiet after either error.

Other behaviours need the bench's scenarios, which compare every request against a model of the address space:
- the contents of each packed word, including padding placement and lane order;
- the sequence of request addresses;
- the exact committed count after an aborted transfer;
- that consumption stops at the failing word.

// File: rtl/wpack_pkg.sv
package wpack_pkg;
  localparam int unsigned WORD_LANES = 4;
  localparam int unsigned LANE_BITS  = $clog2(WORD_LANES);
  localparam int unsigned WORD_BITS  = 8 * WORD_LANES;
  localparam logic [7:0]  PAD_BYTE   = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_REQ,
    S_WAIT,
    S_DONE
  } wp_state_t;
endpackage

// File: rtl/wpack_lanes.sv
module wpack_lanes
  import wpack_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 wr_en,
  input  logic [LANE_BITS-1:0] sel,
  input  logic [7:0]           din,
  output logic [WORD_BITS-1:0] word
);
  for (genvar i = 0; i < WORD_LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word[8*i +: 8] <= PAD_BYTE;
      end else if (clear) begin
        word[8*i +: 8] <= PAD_BYTE;
      end else if (wr_en && sel == LANE_BITS'(i)) begin
        word[8*i +: 8] <= din;
      end
    end
  end
endmodule

// File: rtl/wpack_bound.sv
module wpack_bound #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned DEV_BYTES = 1 << 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              over
);
  localparam int unsigned SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

  logic [SUM_W-1:0] last_excl;

  always_comb begin
    last_excl = SUM_W'(addr) + SUM_W'(len);
    over      = 64'(last_excl) > 64'(DEV_BYTES);
  end
endmodule

// File: rtl/wpack_ctrl.sv
module wpack_ctrl
  import wpack_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LEN_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [LEN_W-1:0]      st_len,
  input  logic                  over,
  input  logic                  in_valid,
  output logic                  in_ready,
  output logic                  wr_en,
  output logic [LANE_BITS-1:0]  lane,
  output logic                  clear,
  output logic                  pg_valid,
  input  logic                  pg_ready,
  output logic [ADDR_W-1:0]     word_addr,
  input  logic                  rsp_valid,
  input  logic                  rsp_fail,
  output logic                  done,
  output logic                  err_io,
  output logic                  err_range,
  output logic [LEN_W-1:0]      committed
);
  localparam int unsigned WA_W = ADDR_W - LANE_BITS;

  wp_state_t            st;
  logic [WA_W-1:0]      waddr;
  logic [LEN_W-1:0]     remain;
  logic [LANE_BITS:0]   inword;
  logic                 take_start;
  logic                 last_byte;

  always_comb begin
    take_start = (st == S_IDLE) && start;
    in_ready   = (st == S_FILL);
    wr_en      = in_ready && in_valid;
    pg_valid   = (st == S_REQ);
    done       = (st == S_DONE);
    clear      = take_start || ((st == S_WAIT) && rsp_valid && !rsp_fail);
    last_byte  = (lane == LANE_BITS'(WORD_LANES - 1)) || (remain == LEN_W'(1));
    word_addr  = {waddr, {LANE_BITS{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      waddr     <= '0;
      lane      <= '0;
      remain    <= '0;
      inword    <= '0;
      committed <= '0;
      err_io    <= 1'b0;
      err_range <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          lane      <= st_addr[LANE_BITS-1:0];
          waddr     <= st_addr[ADDR_W-1:LANE_BITS];
          remain    <= st_len;
          inword    <= '0;
          committed <= '0;
          err_io    <= 1'b0;
          err_range <= 1'b0;
          if (st_len == '0) begin
            st <= S_DONE;
          end else if (over) begin
            err_range <= 1'b1;
            st        <= S_DONE;
          end else begin
            st <= S_FILL;
          end
        end
        S_FILL: if (in_valid) begin
          remain <= remain - LEN_W'(1);
          lane   <= lane + LANE_BITS'(1);
          inword <= inword + (LANE_BITS+1)'(1);
          if (last_byte) st <= S_REQ;
        end
        S_REQ: if (pg_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (rsp_fail) begin
            err_io <= 1'b1;
            st     <= S_DONE;
          end else begin
            committed <= committed + LEN_W'(inword);
            inword    <= '0;
            lane      <= '0;
            waddr     <= waddr + WA_W'(1);
            st        <= (remain == '0) ? S_DONE : S_FILL;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9: zero-length start finishes on the next cycle with nothing committed
  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_start && st_len == '0) |=> (done && committed == '0 && !err_io && !err_range));

  // R10: out-of-range start is refused on the next cycle
  assert_range_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_start && st_len != '0 && over) |=> (done && err_range));

  assert_range_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_range |-> (!pg_valid && !in_ready));

  // R7: after a failed program nothing more moves
  assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_io |-> (!pg_valid && !in_ready));

  // R8: committed count never falls inside a transfer
  assert_commit_mono_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_start |=> (committed >= $past(committed)));

  // R11: done lasts exactly one cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/wpack_top.sv
module wpack_top
  import wpack_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned DEV_BYTES = 1 << 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [LEN_W-1:0]  st_len,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              pg_valid,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [31:0]       pg_data,
  input  logic              pg_ready,
  input  logic              rsp_valid,
  input  logic              rsp_fail,
  output logic              done,
  output logic              err_io,
  output logic              err_range,
  output logic [LEN_W-1:0]  committed
);
  logic                 over;
  logic                 wr_en;
  logic                 clear;
  logic [LANE_BITS-1:0] lane;
  logic [WORD_BITS-1:0] word;

  wpack_bound #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)) u_bound (
    .addr (st_addr),
    .len  (st_len),
    .over (over)
  );

  wpack_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .st_addr   (st_addr),
    .st_len    (st_len),
    .over      (over),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .lane      (lane),
    .clear     (clear),
    .pg_valid  (pg_valid),
    .pg_ready  (pg_ready),
    .word_addr (pg_addr),
    .rsp_valid (rsp_valid),
    .rsp_fail  (rsp_fail),
    .done      (done),
    .err_io    (err_io),
    .err_range (err_range),
    .committed (committed)
  );

  wpack_lanes u_lanes (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .wr_en (wr_en),
    .sel   (lane),
    .din   (in_data),
    .word  (word)
  );

  assign pg_data = word;

  // R6: a pending request is held steady under back-pressure
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && !pg_ready) |=> (pg_valid && $stable(pg_addr) && $stable(pg_data)));

  // R6: stream side and request side are never open together
  assert_side_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && pg_valid));
endmodule

// File: tb/wpack_top_tb.sv
`timescale 1ns/1ps
module wpack_top_tb;
  localparam int ADDR_W = 10;
  localparam int LEN_W  = 10;
  localparam int DEV    = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [LEN_W-1:0]  st_len = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic pg_valid;
  logic [ADDR_W-1:0] pg_addr;
  logic [31:0] pg_data;
  logic pg_ready = 1'b0;
  logic rsp_valid = 1'b0;
  logic rsp_fail = 1'b0;
  logic done, err_io, err_range;
  logic [LEN_W-1:0] committed;

  always #2 clk = ~clk;

  wpack_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_BYTES(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .st_addr(st_addr), .st_len(st_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pg_valid(pg_valid), .pg_addr(pg_addr), .pg_data(pg_data), .pg_ready(pg_ready),
    .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .done(done), .err_io(err_io),
    .err_range(err_range), .committed(committed)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  logic [7:0] mem [0:63];
  int b_start = 0, b_len = 0, fail_at = -1;
  bit active = 1'b0, tb_clr = 1'b0;
  int ptr = 0, widx = 0, issued = 0, dly = 0;
  bit pend = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int idx);
    logic [31:0] w;
    int base;
    base = (b_start & ~3) + 4 * idx;
    for (int j = 0; j < 4; j++) begin
      int a;
      a = base + j;
      if (a >= b_start && a < b_start + b_len) w[8*j +: 8] = mem[a - b_start];
      else w[8*j +: 8] = 8'hFF;
    end
    return w;
  endfunction

  function automatic int bytes_before(input int k);
    int v;
    v = (b_start & ~3) + 4 * k - b_start;
    if (v < 0) v = 0;
    if (v > b_len) v = b_len;
    return v;
  endfunction

  // stream source and sequencer drive on the falling edge
  always @(negedge clk) begin
    in_valid  <= active && (ptr < b_len) && ($urandom % 4 != 0);
    in_data   <= mem[ptr < 64 ? ptr : 0];
    pg_ready  <= !pend && ($urandom % 2 == 0);
    rsp_valid <= pend && (dly == 0);
    rsp_fail  <= pend && (dly == 0) && (widx == fail_at);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (tb_clr) begin
      ptr <= 0; widx <= 0; issued <= 0; pend <= 1'b0; dly <= 0;
    end else begin
      if (in_valid && in_ready) ptr <= ptr + 1;
      if (pg_valid && pg_ready) begin
        chk(pg_addr == ADDR_W'((b_start & ~3) + 4 * issued), "R1 R5 request address",
            pg_addr, (b_start & ~3) + 4 * issued);
        chk(pg_data == exp_word(issued), "R2 R3 R4 packed word", pg_data, exp_word(issued));
        issued <= issued + 1;
        pend   <= 1'b1;
        dly    <= $urandom % 3;
      end
      if (rsp_valid) begin
        pend <= 1'b0;
        widx <= widx + 1;
      end else if (pend && dly > 0) begin
        dly <= dly - 1;
      end
    end
  end

  task automatic run(input int s, input int l, input int f);
    int cyc, nw, exp_c, exp_ptr, exp_iss, p_ptr, p_iss;
    bit exp_rng, exp_io;
    @(negedge clk);
    b_start = s; b_len = l; fail_at = f;
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    tb_clr = 1'b1;
    @(negedge clk);
    tb_clr = 1'b0;
    active = 1'b1;
    start = 1'b1; st_addr = ADDR_W'(s); st_len = LEN_W'(l);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R11 transfer finished", done, 1);
    nw = (l == 0) ? 0 : ((s + l + 3) >> 2) - (s >> 2);
    exp_rng = (l != 0) && (s + l > DEV);
    exp_io  = !exp_rng && (f >= 0) && (f < nw);
    if (l == 0 || exp_rng) begin
      chk(cyc == 1, "R9 R10 one-cycle completion", cyc, 1);
      exp_c = 0; exp_ptr = 0; exp_iss = 0;
    end else if (exp_io) begin
      exp_c = bytes_before(f); exp_ptr = bytes_before(f + 1); exp_iss = f + 1;
    end else begin
      exp_c = l; exp_ptr = l; exp_iss = nw;
    end
    chk(err_range == exp_rng, "R10 range flag", err_range, exp_rng);
    chk(err_io == exp_io, "R7 io flag", err_io, exp_io);
    chk(committed == LEN_W'(exp_c), "R8 R9 committed count", committed, exp_c);
    chk(issued == exp_iss, "R5 R7 R10 request count", issued, exp_iss);
    chk(ptr == exp_ptr, "R7 R10 bytes consumed", ptr, exp_ptr);
    p_ptr = ptr; p_iss = issued;
    @(negedge clk);
    chk(done == 1'b0, "R11 done pulse width", done, 0);
    active = 1'b0;
    repeat (3) @(negedge clk);
    chk(ptr == p_ptr && issued == p_iss, "R7 quiet after end", ptr, p_ptr);
    chk(committed == LEN_W'(exp_c) && err_io == exp_io, "R11 status held",
        committed, exp_c);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!in_ready && !pg_valid && !done && committed == '0, "R11 reset state",
        {in_ready, pg_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(1, 2, -1);      // R2 R3 data ends inside first word
    run(0, 4, -1);      // R4 aligned single word
    run(3, 1, -1);      // R2 last lane only
    run(2, 9, -1);      // R2 R3 leading, middle, trailing
    run(4, 13, -1);     // R3 trailing partial
    run(5, 0, -1);      // R9 zero length
    run(250, 10, -1);   // R10 past device end
    run(240, 16, -1);   // R10 ends exactly at device end
    run(1, 20, 1);      // R7 R8 fail on second word
    run(2, 7, 0);       // R7 R8 fail on first word
    run(0, 12, 2);      // R7 fail on last word
    for (int t = 0; t < 40; t++) begin
      int s, l, f, nw;
      s = $urandom % 256;
      l = $urandom % 65;
      nw = (l == 0) ? 1 : ((s + l + 3) >> 2) - (s >> 2);
      f = ($urandom % 4 == 0) ? int'($urandom % nw) : -1;
      run(s, l, f);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule